// File: doc/BRIEF.md
# Per-Nibble Delay Tap Register File

This block keeps the delay settings of one nibble of a memory interface's physical layer in a small register file reached through a plain address, write-data and write-enable port with a combinational read path. It stores a 10-bit tap count for each of six input delays and six output delays. It also stores a 10-bit rising-edge strobe delay, a 10-bit falling-edge strobe delay and a 5-bit coarse delay with 32 positions. Each value is driven on an output bus so that a behavioural delay-line model can follow it. The block does not model the delay lines themselves.

A write to a delay register carries an operation code that loads a value, steps it by one tap in either direction, or leaves it unchanged. A broadcast command moves every unmasked input and output delay by one tap with a single write. A separate command issues per-bitslice reset pulses, filtered by a reset mask and stretched to a minimum width. Calibration firmware uses the block to sweep delays one tap at a time.

Top module: `nib_dly_regfile`

## Requirements
- R1: After reset every delay value, both mask registers, the sticky status bits and the pending broadcast bit read 0, and no reset pulse is active.
- R2: Output delay of slice i sits at address 0x0B+i and input delay of slice i at 0x12+i (i = 0..5). The operation code is wdata[11:10]: 00 loads wdata[9:0], 01 adds one tap, 10 subtracts one tap, 11 leaves the value unchanged. Reads return the value zero-extended to 16 bits, and the same value appears on odly_o/idly_o bits [10i+9:10i].
- R3: An input or output delay wraps from 0x3FF to 0x000 on a step up and from 0x000 to 0x3FF on a step down.
- R4: The rising strobe delay (0x07) and the falling strobe delay (0x08) accept the same four operation codes, wrap the same way, and appear on rise_o and fall_o.
- R5: The coarse delay (0x18) uses the same operation codes. A load takes wdata[4:0]. Steps saturate: up at 31 holds 31, and down at 0 holds 0.
- R6: A step down attempted at coarse 0 sets a sticky underflow flag, read at bit 6 of address 0x03. A step up attempted at 31 sets a sticky overflow flag at bit 7. Writing 0x03 with wdata[15]=1 clears both flags.
- R7: Broadcast mask 0x05 holds 12 bits: bits [5:0] exclude output delay slices and bits [11:6] exclude input delay slices. Writing 0x06 with bit 0 set arms one step, up when bit 1 is 0 and down when bit 1 is 1. The step is applied at the next clock edge to every unexcluded input and output delay. Reading 0x06 returns the armed bit at bit 0, which clears itself once the step is applied, and the direction at bit 1. Strobe and coarse delays are not affected.
- R8: A direct write to a delay register in the same cycle that a broadcast step is applied takes precedence for that register; the register does not also receive the broadcast step.
- R9: Reset mask 0x11 holds 6 bits. Writing 0x03 with wdata[i]=1 raises slice_rst_o[i] unless mask bit i is set.
- R10: Each reset pulse stays high for exactly 8 clock cycles (RST_CYC). A new request on an active slice restarts the full count. Address 0x03 bits [5:0] read the active pulses.
- R11: Every address outside 0x03, 0x05-0x08, 0x0B-0x18 reads as zero, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 7 | Register address |
| wdata | input | 16 | Write data: operation code, value or control bits |
| rdata | output | 16 | Combinational read data for addr |
| odly_o | output | 60 | Output delay taps, slice i at bits [10i+9:10i] |
| idly_o | output | 60 | Input delay taps, slice i at bits [10i+9:10i] |
| rise_o | output | 10 | Rising-edge strobe delay taps |
| fall_o | output | 10 | Falling-edge strobe delay taps |
| crse_o | output | 5 | Coarse delay taps |
| slice_rst_o | output | 6 | Per-bitslice reset pulses |

## Verification
Several behaviours are checked by assertions on every cycle:
- the wrap of slice 0 delays at both ends of the range;
- coarse saturation at the top;
- that a reset pulse only rises after an unmasked request;
- that no pulse falls before eight cycles;
- the self-clearing of the broadcast arm bit;
- zero reads from unmapped addresses.

Other behaviours can only be shown by the bench's scenarios:
- the arithmetic of each operation code on all fourteen 10-bit registers;
- exhaustive coarse loads;
- broadcasts under several mask patterns in both directions;
- direct-write precedence on a broadcast cycle;
- pulse restarts;
- the absence of side effects from unmapped writes, confirmed by full read-back sweeps.

// File: rtl/nib_dly_pkg.sv
package nib_dly_pkg;

   typedef enum logic [1:0] {
      OP_LOAD = 2'b00,
      OP_INC  = 2'b01,
      OP_DEC  = 2'b10,
      OP_NOP  = 2'b11
   } tap_op_e;

   // register map (neighbouring firmware decodes these offsets)
   localparam int A_RCTRL = 'h03;
   localparam int A_BMASK = 'h05;
   localparam int A_BCTRL = 'h06;
   localparam int A_RISE  = 'h07;
   localparam int A_FALL  = 'h08;
   localparam int A_ODLY0 = 'h0B;
   localparam int A_RMASK = 'h11;
   localparam int A_IDLY0 = 'h12;
   localparam int A_CRSE  = 'h18;

   localparam int OP_LSB    = 10;
   localparam int ST_UNF    = 6;
   localparam int ST_OVF    = 7;
   localparam int MAX_SLICE = 6;

   function automatic bit is_mapped(int a, int nslice);
      return (a == A_RCTRL) || (a == A_BMASK) || (a == A_BCTRL) ||
             (a == A_RISE) || (a == A_FALL) || (a == A_RMASK) || (a == A_CRSE) ||
             (a >= A_ODLY0 && a < A_ODLY0 + nslice) ||
             (a >= A_IDLY0 && a < A_IDLY0 + nslice);
   endfunction

endpackage

// File: rtl/nib_tap_ctr.sv
module nib_tap_ctr #(
   parameter int unsigned W   = 10,
   parameter bit          SAT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic [W-1:0] nxt;

   generate
      if (SAT) begin : g_sat
         always_comb begin
            nxt = q;
            if (ld)                    nxt = ld_val;
            else if (inc && q != TOP)  nxt = q + 1'b1;
            else if (dec && q != '0)   nxt = q - 1'b1;
         end
      end else begin : g_wrap
         always_comb begin
            nxt = q;
            if (ld)       nxt = ld_val;
            else if (inc) nxt = q + 1'b1;
            else if (dec) nxt = q - 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

endmodule

// File: rtl/nib_rst_stretch.sv
module nib_rst_stretch #(
   parameter int unsigned N   = 6,
   parameter int unsigned CYC = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] trig,
   output logic [N-1:0] pulse
);

   localparam int unsigned CW = $clog2(CYC + 1);

   generate
      for (genvar i = 0; i < N; i++) begin : g_slice
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)          cnt <= '0;
            else if (trig[i])    cnt <= CW'(CYC);
            else if (cnt != '0)  cnt <= cnt - 1'b1;
         end
         assign pulse[i] = (cnt != '0);
      end
   endgenerate

endmodule

// File: rtl/nib_dly_regfile.sv
module nib_dly_regfile
   import nib_dly_pkg::*;
#(
   parameter int unsigned NSLICE  = 6,
   parameter int unsigned TAP_W   = 10,
   parameter int unsigned CRSE_W  = 5,
   parameter int unsigned RST_CYC = 8,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned ADDR_W  = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata,
   output logic [NSLICE*TAP_W-1:0]  odly_o,
   output logic [NSLICE*TAP_W-1:0]  idly_o,
   output logic [TAP_W-1:0]         rise_o,
   output logic [TAP_W-1:0]         fall_o,
   output logic [CRSE_W-1:0]        crse_o,
   output logic [NSLICE-1:0]        slice_rst_o
);

   localparam int unsigned BM_W = 2 * NSLICE;
   localparam logic [CRSE_W-1:0] CRSE_TOP = {CRSE_W{1'b1}};

   // elaboration-time parameter checks
   generate
      if (NSLICE < 1 || NSLICE > MAX_SLICE) begin : g_bad_nslice
         $error("NSLICE must lie in 1..6");
      end
      if (TAP_W > OP_LSB || CRSE_W > TAP_W || CRSE_W < 1) begin : g_bad_w
         $error("tap widths must fit below the operation field");
      end
      if (DATA_W < 16 || ADDR_W < 7) begin : g_bad_bus
         $error("DATA_W must be >= 16 and ADDR_W >= 7");
      end
      if (RST_CYC < 1) begin : g_bad_cyc
         $error("RST_CYC must be at least 1");
      end
   endgenerate

   tap_op_e op;
   assign op = tap_op_e'(wdata[OP_LSB+1:OP_LSB]);

   function automatic logic hit(input logic [ADDR_W-1:0] a_in, input int a_ref);
      return (a_in == ADDR_W'(a_ref));
   endfunction

   // control registers
   logic [BM_W-1:0]   bmask_q;
   logic [NSLICE-1:0] rst_mask_q;
   logic              bc_go_q, bc_dir_q;
   logic              unf_st, ovf_st;

   logic wr_rctrl, wr_bctrl, st_clr;
   assign wr_rctrl = wr_en && hit(addr, A_RCTRL);
   assign wr_bctrl = wr_en && hit(addr, A_BCTRL);
   assign st_clr   = wr_rctrl && wdata[DATA_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bmask_q    <= '0;
         rst_mask_q <= '0;
      end else begin
         if (wr_en && hit(addr, A_BMASK)) bmask_q    <= wdata[BM_W-1:0];
         if (wr_en && hit(addr, A_RMASK)) rst_mask_q <= wdata[NSLICE-1:0];
      end
   end

   // broadcast arm bit: set by a write, cleared after one application
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bc_go_q  <= 1'b0;
         bc_dir_q <= 1'b0;
      end else if (wr_bctrl) begin
         bc_go_q  <= wdata[0];
         bc_dir_q <= wdata[1];
      end else if (bc_go_q) begin
         bc_go_q  <= 1'b0;
      end
   end

   logic bc_up, bc_dn;
   assign bc_up = bc_go_q && !bc_dir_q;
   assign bc_dn = bc_go_q &&  bc_dir_q;

   // input / output delay taps
   logic [TAP_W-1:0] odly_q [NSLICE];
   logic [TAP_W-1:0] idly_q [NSLICE];

   generate
      for (genvar i = 0; i < NSLICE; i++) begin : g_io
         logic o_hit, i_hit;
         assign o_hit = wr_en && hit(addr, A_ODLY0 + i);
         assign i_hit = wr_en && hit(addr, A_IDLY0 + i);

         nib_tap_ctr #(.W(TAP_W), .SAT(1'b0)) u_odly (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (o_hit && op == OP_LOAD),
            .ld_val (wdata[TAP_W-1:0]),
            .inc    (o_hit ? (op == OP_INC) : (bc_up && !bmask_q[i])),
            .dec    (o_hit ? (op == OP_DEC) : (bc_dn && !bmask_q[i])),
            .q      (odly_q[i])
         );

         nib_tap_ctr #(.W(TAP_W), .SAT(1'b0)) u_idly (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (i_hit && op == OP_LOAD),
            .ld_val (wdata[TAP_W-1:0]),
            .inc    (i_hit ? (op == OP_INC) : (bc_up && !bmask_q[NSLICE+i])),
            .dec    (i_hit ? (op == OP_DEC) : (bc_dn && !bmask_q[NSLICE+i])),
            .q      (idly_q[i])
         );

         assign odly_o[i*TAP_W +: TAP_W] = odly_q[i];
         assign idly_o[i*TAP_W +: TAP_W] = idly_q[i];
      end
   endgenerate

   // strobe edge delays
   logic r_hit, f_hit, c_hit;
   assign r_hit = wr_en && hit(addr, A_RISE);
   assign f_hit = wr_en && hit(addr, A_FALL);
   assign c_hit = wr_en && hit(addr, A_CRSE);

   nib_tap_ctr #(.W(TAP_W), .SAT(1'b0)) u_rise (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (r_hit && op == OP_LOAD),
      .ld_val (wdata[TAP_W-1:0]),
      .inc    (r_hit && op == OP_INC),
      .dec    (r_hit && op == OP_DEC),
      .q      (rise_o)
   );

   nib_tap_ctr #(.W(TAP_W), .SAT(1'b0)) u_fall (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (f_hit && op == OP_LOAD),
      .ld_val (wdata[TAP_W-1:0]),
      .inc    (f_hit && op == OP_INC),
      .dec    (f_hit && op == OP_DEC),
      .q      (fall_o)
   );

   // coarse delay: saturating, with sticky limit flags
   logic c_inc, c_dec;
   assign c_inc = c_hit && op == OP_INC;
   assign c_dec = c_hit && op == OP_DEC;

   nib_tap_ctr #(.W(CRSE_W), .SAT(1'b1)) u_crse (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (c_hit && op == OP_LOAD),
      .ld_val (wdata[CRSE_W-1:0]),
      .inc    (c_inc),
      .dec    (c_dec),
      .q      (crse_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         unf_st <= 1'b0;
         ovf_st <= 1'b0;
      end else begin
         unf_st <= (unf_st && !st_clr) || (c_dec && crse_o == '0);
         ovf_st <= (ovf_st && !st_clr) || (c_inc && crse_o == CRSE_TOP);
      end
   end

   // per-bitslice reset pulses
   logic [NSLICE-1:0] rst_trig;
   assign rst_trig = wr_rctrl ? (wdata[NSLICE-1:0] & ~rst_mask_q) : '0;

   nib_rst_stretch #(.N(NSLICE), .CYC(RST_CYC)) u_rst (
      .clk   (clk),
      .rst_n (rst_n),
      .trig  (rst_trig),
      .pulse (slice_rst_o)
   );

   // read mux
   always_comb begin
      rdata = '0;
      if (hit(addr, A_RCTRL)) begin
         rdata[NSLICE-1:0] = slice_rst_o;
         rdata[ST_UNF]     = unf_st;
         rdata[ST_OVF]     = ovf_st;
      end
      if (hit(addr, A_BMASK)) rdata = DATA_W'(bmask_q);
      if (hit(addr, A_BCTRL)) rdata = DATA_W'({bc_dir_q, bc_go_q});
      if (hit(addr, A_RISE))  rdata = DATA_W'(rise_o);
      if (hit(addr, A_FALL))  rdata = DATA_W'(fall_o);
      if (hit(addr, A_RMASK)) rdata = DATA_W'(rst_mask_q);
      if (hit(addr, A_CRSE))  rdata = DATA_W'(crse_o);
      for (int i = 0; i < NSLICE; i++) begin
         if (hit(addr, A_ODLY0 + i)) rdata = DATA_W'(odly_q[i]);
         if (hit(addr, A_IDLY0 + i)) rdata = DATA_W'(idly_q[i]);
      end
   end

endmodule

// File: rtl/nib_dly_regfile_chk.sv
module nib_dly_regfile_chk
   import nib_dly_pkg::*;
#(
   parameter int unsigned NSLICE  = 6,
   parameter int unsigned TAP_W   = 10,
   parameter int unsigned CRSE_W  = 5,
   parameter int unsigned RST_CYC = 8,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned ADDR_W  = 7
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic [ADDR_W-1:0]       addr,
   input logic [DATA_W-1:0]       wdata,
   input logic [DATA_W-1:0]       rdata,
   input logic [NSLICE*TAP_W-1:0] odly_o,
   input logic [NSLICE*TAP_W-1:0] idly_o,
   input logic [CRSE_W-1:0]       crse_o,
   input logic [NSLICE-1:0]       slice_rst_o,
   input logic [NSLICE-1:0]       rst_mask_q,
   input logic                    bc_go_q
);

   localparam int unsigned HW = $clog2(RST_CYC + 2);

   logic [1:0] opf;
   assign opf = wdata[OP_LSB+1:OP_LSB];

   // R3: slice 0 output delay wraps upward
   a_r3_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(A_ODLY0) && opf == 2'b01 && odly_o[TAP_W-1:0] == '1)
      |=> odly_o[TAP_W-1:0] == '0);

   // R3: slice 0 input delay wraps downward
   a_r3_wrap_dn: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(A_IDLY0) && opf == 2'b10 && idly_o[TAP_W-1:0] == '0)
      |=> idly_o[TAP_W-1:0] == '1);

   // R5: coarse delay holds at the top
   a_r5_crse_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(A_CRSE) && opf == 2'b01 && crse_o == '1)
      |=> crse_o == '1);

   // R7: arm bit clears after one application unless rewritten
   a_r7_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_go_q && !(wr_en && addr == ADDR_W'(A_BCTRL))) |=> !bc_go_q);

   // R11: unmapped addresses read zero
   a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !is_mapped(int'(addr), int'(NSLICE)) |-> rdata == '0);

   generate
      for (genvar i = 0; i < NSLICE; i++) begin : g_pulse
         logic [HW-1:0] hi_cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)                          hi_cnt <= '0;
            else if (!slice_rst_o[i])            hi_cnt <= '0;
            else if (hi_cnt != HW'(RST_CYC + 1)) hi_cnt <= hi_cnt + 1'b1;
         end

         // R9: a pulse only starts after an unmasked request
         a_r9_masked_start: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(slice_rst_o[i]) |->
               $past(wr_en && addr == ADDR_W'(A_RCTRL) && wdata[i] && !rst_mask_q[i]));

         // R10: no pulse shorter than RST_CYC cycles
         a_r10_min_width: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(slice_rst_o[i]) |-> hi_cnt >= HW'(RST_CYC));
      end
   endgenerate

endmodule

bind nib_dly_regfile nib_dly_regfile_chk #(
   .NSLICE(NSLICE), .TAP_W(TAP_W), .CRSE_W(CRSE_W),
   .RST_CYC(RST_CYC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .addr        (addr),
   .wdata       (wdata),
   .rdata       (rdata),
   .odly_o      (odly_o),
   .idly_o      (idly_o),
   .crse_o      (crse_o),
   .slice_rst_o (slice_rst_o),
   .rst_mask_q  (rst_mask_q),
   .bc_go_q     (bc_go_q)
);

// File: tb/nib_dly_regfile_tb.sv
module nib_dly_regfile_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [6:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [59:0] odly_o, idly_o;
   logic [9:0]  rise_o, fall_o;
   logic [4:0]  crse_o;
   logic [5:0]  slice_rst_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   nib_dly_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .odly_o(odly_o), .idly_o(idly_o), .rise_o(rise_o),
      .fall_o(fall_o), .crse_o(crse_o), .slice_rst_o(slice_rst_o)
   );

   // reference state
   logic [9:0]  m_od [6];
   logic [9:0]  m_id [6];
   logic [9:0]  m_rise, m_fall;
   logic [4:0]  m_cr;
   logic        m_unf, m_ovf, m_dir;
   logic [11:0] m_bm;
   logic [5:0]  m_rm;

   function automatic logic [9:0] step(logic [9:0] v, logic [1:0] op, logic [9:0] ld);
      case (op)
         2'b00:   return ld;
         2'b01:   return v + 10'd1;
         2'b10:   return v - 10'd1;
         default: return v;
      endcase
   endfunction

   function automatic logic [15:0] exp_rd(int a);
      if (a == 3)  return {8'h0, m_ovf, m_unf, 6'h0};
      if (a == 5)  return {4'h0, m_bm};
      if (a == 6)  return {14'h0, m_dir, 1'b0};
      if (a == 7)  return {6'h0, m_rise};
      if (a == 8)  return {6'h0, m_fall};
      if (a >= 11 && a <= 16) return {6'h0, m_od[a-11]};
      if (a == 17) return {10'h0, m_rm};
      if (a >= 18 && a <= 23) return {6'h0, m_id[a-18]};
      if (a == 24) return {11'h0, m_cr};
      return 16'h0;
   endfunction

   function automatic logic [15:0] bus_val(int a);
      if (a == 7)  return {6'h0, rise_o};
      if (a == 8)  return {6'h0, fall_o};
      if (a >= 11 && a <= 16) return {6'h0, odly_o[(a-11)*10 +: 10]};
      if (a >= 18 && a <= 23) return {6'h0, idly_o[(a-18)*10 +: 10]};
      if (a == 24) return {11'h0, crse_o};
      return 16'h0;
   endfunction

   function automatic bit is_dly(int a);
      return a == 7 || a == 8 || a == 24 || (a >= 11 && a <= 16) || (a >= 18 && a <= 23);
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = 7'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic chk_reg(int a, string req);
      addr = 7'(a);
      #1;
      check(req, 64'(rdata), 64'(exp_rd(a)));
      if (is_dly(a)) check(req, 64'(bus_val(a)), 64'(exp_rd(a)));
      addr = '0;
   endtask

   task automatic check_all(string req);
      for (int a = 0; a < 128; a++) begin
         @(negedge clk);
         addr = 7'(a);
         #1;
         check(req, 64'(rdata), 64'(exp_rd(a)));
         if (is_dly(a)) check(req, 64'(bus_val(a)), 64'(exp_rd(a)));
      end
      addr = '0;
   endtask

   task automatic tap_op(int a, logic [1:0] op, logic [9:0] v, string req);
      wr(a, {4'h0, op, v});
      if (a == 7) m_rise = step(m_rise, op, v);
      else if (a == 8) m_fall = step(m_fall, op, v);
      else if (a >= 11 && a <= 16) m_od[a-11] = step(m_od[a-11], op, v);
      else if (a >= 18 && a <= 23) m_id[a-18] = step(m_id[a-18], op, v);
      else if (a == 24) begin
         case (op)
            2'b00: m_cr = v[4:0];
            2'b01: if (m_cr == 5'd31) m_ovf = 1'b1; else m_cr = m_cr + 5'd1;
            2'b10: if (m_cr == 5'd0)  m_unf = 1'b1; else m_cr = m_cr - 5'd1;
            default: ;
         endcase
      end
      chk_reg(a, req);
   endtask

   function automatic int io_addr(int k);
      return (k < 6) ? 11 + k : 18 + (k - 6);
   endfunction

   task automatic load_io_base(int seed);
      for (int k = 0; k < 12; k++) tap_op(io_addr(k), 2'b00, 10'((k * 131 + seed) & 10'h3FF), "R2");
   endtask

   task automatic bcast(logic dir);
      wr(6, {14'h0, dir, 1'b1});
      m_dir = dir;
      addr = 7'd6;
      #1;
      check("R7 armed", 64'(rdata), 64'({dir, 1'b1}));
      addr = '0;
      for (int k = 0; k < 6; k++) begin
         if (!m_bm[k])   m_od[k] = dir ? m_od[k] - 10'd1 : m_od[k] + 10'd1;
         if (!m_bm[6+k]) m_id[k] = dir ? m_id[k] - 10'd1 : m_id[k] + 10'd1;
      end
   endtask

   task automatic pulse_test(logic [5:0] mask, logic [5:0] req);
      int cnt [6];
      wr(17, {10'h0, mask});
      m_rm = mask;
      chk_reg(17, "R9 mask");
      wr(3, {10'h0, req});
      addr = 7'd3;
      #1;
      check("R10 read pulses", 64'(rdata[5:0]), 64'(req & ~mask));
      addr = '0;
      for (int s = 0; s < 6; s++) cnt[s] = 0;
      for (int c = 0; c < 20; c++) begin
         for (int s = 0; s < 6; s++) if (slice_rst_o[s]) cnt[s]++;
         @(negedge clk);
      end
      for (int s = 0; s < 6; s++)
         check("R9/R10 pulse width", 64'(cnt[s]), (req[s] && !mask[s]) ? 64'd8 : 64'd0);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 6; k++) begin m_od[k] = '0; m_id[k] = '0; end
      m_rise = '0; m_fall = '0; m_cr = '0; m_unf = 0; m_ovf = 0; m_dir = 0;
      m_bm = '0; m_rm = '0;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state on every address and output
      check("R1 pulses", 64'(slice_rst_o), 64'h0);
      check_all("R1 reset state");

      // R2: each operation code on every input/output delay
      for (int k = 0; k < 12; k++) begin
         tap_op(io_addr(k), 2'b00, 10'((k * 83 + 17) & 10'h3FF), "R2 load");
         tap_op(io_addr(k), 2'b01, 10'h2AA, "R2 inc");
         tap_op(io_addr(k), 2'b01, 10'h000, "R2 inc");
         tap_op(io_addr(k), 2'b10, 10'h155, "R2 dec");
         tap_op(io_addr(k), 2'b11, 10'h000, "R2 nop");
      end

      // R3: wrap at both ends
      for (int k = 0; k < 12; k++) begin
         tap_op(io_addr(k), 2'b00, 10'h3FF, "R3 load top");
         tap_op(io_addr(k), 2'b01, 10'h0, "R3 wrap up");
         tap_op(io_addr(k), 2'b10, 10'h0, "R3 wrap down");
      end

      // R4: strobe edge delays
      for (int a = 7; a <= 8; a++) begin
         tap_op(a, 2'b00, 10'h3FE, "R4 load");
         tap_op(a, 2'b01, 10'h0, "R4 inc");
         tap_op(a, 2'b01, 10'h0, "R4 wrap up");
         tap_op(a, 2'b10, 10'h0, "R4 wrap down");
         tap_op(a, 2'b11, 10'h1, "R4 nop");
      end
      check_all("R2/R4 sweep");

      // R5: exhaustive coarse loads, upper load bits ignored
      for (int v = 0; v < 32; v++) tap_op(24, 2'b00, 10'(v) | 10'h3E0, "R5 load");
      tap_op(24, 2'b00, 10'd30, "R5 load");
      tap_op(24, 2'b01, 10'd0, "R5 inc");
      chk_reg(3, "R6 no overflow yet");
      tap_op(24, 2'b01, 10'd0, "R5 sat top");
      chk_reg(3, "R6 overflow sticky");
      tap_op(24, 2'b10, 10'd0, "R5 dec");
      chk_reg(3, "R6 overflow stays");
      wr(3, 16'h8000);
      m_ovf = 0; m_unf = 0;
      chk_reg(3, "R6 clear");
      tap_op(24, 2'b00, 10'd1, "R5 load");
      tap_op(24, 2'b10, 10'd0, "R5 dec");
      chk_reg(3, "R6 no underflow yet");
      tap_op(24, 2'b10, 10'd0, "R5 sat bottom");
      chk_reg(3, "R6 underflow sticky");
      wr(3, 16'h8000);
      m_ovf = 0; m_unf = 0;
      chk_reg(3, "R6 clear");

      // R7: broadcast under several masks, both directions
      begin
         logic [11:0] masks [5];
         masks[0] = 12'h000; masks[1] = 12'hFFF; masks[2] = 12'h0A5;
         masks[3] = 12'hF0F; masks[4] = 12'h555;
         for (int mi = 0; mi < 5; mi++) begin
            wr(5, {4'h0, masks[mi]});
            m_bm = masks[mi];
            load_io_base(mi * 7 + ((mi == 2) ? 1023 - 131 * 5 : 0));
            tap_op(io_addr(0), 2'b00, 10'h3FF, "R7 edge");
            tap_op(io_addr(6), 2'b00, 10'h000, "R7 edge");
            bcast(1'b0);
            check_all("R7 broadcast up");
            bcast(1'b1);
            check_all("R7 broadcast down");
         end
      end

      // R8: direct load wins on the broadcast cycle
      wr(5, 16'h0000);
      m_bm = '0;
      load_io_base(300);
      @(negedge clk);
      wr_en = 1'b1; addr = 7'd6; wdata = 16'h0001;
      @(negedge clk);
      addr = 7'd11; wdata = {4'h0, 2'b00, 10'h155};
      @(negedge clk);
      wr_en = 1'b0; addr = '0; wdata = '0;
      m_dir = 1'b0;
      for (int k = 1; k < 6; k++) m_od[k] = m_od[k] + 10'd1;
      for (int k = 0; k < 6; k++) m_id[k] = m_id[k] + 10'd1;
      m_od[0] = 10'h155;
      check_all("R8 direct load wins");

      // R8: direct step on the broadcast cycle gives a single step
      @(negedge clk);
      wr_en = 1'b1; addr = 7'd6; wdata = 16'h0001;
      @(negedge clk);
      addr = 7'd18; wdata = {4'h0, 2'b01, 10'h0};
      @(negedge clk);
      wr_en = 1'b0; addr = '0; wdata = '0;
      for (int k = 0; k < 6; k++) m_od[k] = m_od[k] + 10'd1;
      for (int k = 0; k < 6; k++) m_id[k] = m_id[k] + 10'd1;
      check_all("R8 single step");

      // R9/R10: masked reset pulses and width
      pulse_test(6'h00, 6'h3F);
      pulse_test(6'h2A, 6'h3F);
      pulse_test(6'h3F, 6'h3F);
      pulse_test(6'h05, 6'h1C);

      // R10: restart of an active pulse
      wr(17, 16'h0000);
      m_rm = '0;
      wr(3, 16'h0001);
      repeat (3) @(negedge clk);
      wr(3, 16'h0001);
      begin
         int cnt = 0;
         for (int c = 0; c < 20; c++) begin
            if (slice_rst_o[0]) cnt++;
            @(negedge clk);
         end
         check("R10 restart", 64'(cnt), 64'd8);
      end

      // R11: unmapped writes change nothing
      begin
         int ua [7];
         ua[0] = 0; ua[1] = 4; ua[2] = 9; ua[3] = 10; ua[4] = 25; ua[5] = 64; ua[6] = 127;
         for (int u = 0; u < 7; u++) wr(ua[u], 16'h0000);
         for (int u = 0; u < 7; u++) wr(ua[u], 16'h8FFF);
      end
      check("R11 no pulse", 64'(slice_rst_o), 64'h0);
      check_all("R11 unmapped");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule